// File: doc/BRIEF.md
# Station ID Physical-to-Logical Remapper

This block turns the physical fabric ID of a coherent station into the logical fabric ID that address denormalization needs. The fabric ID is split into node bits (upper field) and component bits (lower field). There are three paths:

- **Pass-through:** the ID leaves unchanged.
- **Search:** a programmable table of component values is searched. The position of the first matching entry becomes the logical component, and it is joined to the original node bits.
- **Fixed:** used on heterogeneous systems. A hard-wired permutation of a 32-entry instance number gives the logical component, and a separate node ID is placed above it.

Requests arrive on a valid/ready stream and results leave on a second one, through a single output register. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays on the output pins, unchanged, for as long as `rsp_valid` is high and `rsp_ready` is low. The table is loaded through a plain write port. A write takes effect only while the block is idle, which means no request is offered and no result is held.

Top module: `stid_remapper`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: With `fixed_mode`=0, `remap_en`=0 and `six_way`=0, the result is the physical ID unchanged, with `rsp_miss`=0 and `rsp_range_err`=0.
- R3: In the search path, the key is `phys_id[5:0]`. Table entries are compared from index 0 upward and the lowest matching index wins. The result is `{phys_id[11:6], 6'(index)}`.
- R4: If no table entry matches the key, the index used is 16, so the result is `{phys_id[11:6], 6'd16}`, and `rsp_miss`=1.
- R5: `six_way`=1 selects the search path even when `remap_en`=0.
- R6: With `fixed_mode`=1, the table and the enables are ignored. The result is `(node_id << 6) | map(inst_id)`. Here `map` keeps bits 4 and 1:0 of the instance and inverts bits 3:2. So instances 0-3 go to 12-15, 4-7 to 8-11, 8-11 to 4-7, 12-15 to 0-3, and 16-31 follow the same pattern offset by 16.
- R7: With `fixed_mode`=1 and `inst_id` of 32 or more, the result is all ones (12'hFFF) and `rsp_range_err`=1.
- R8: An accepted request produces `rsp_valid`=1 on the next clock edge. `req_ready` is 0 while a held result is not being drained.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the result stays valid and all result pins are stable.
- R10: A table write is discarded if it is presented while `req_valid` or `rsp_valid` is high. Only an idle write changes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| phys_id | input | 12 | Physical fabric ID: node in [11:6], component in [5:0] |
| inst_id | input | 6 | Instance number for the fixed path |
| node_id | input | 6 | Node number for the fixed path |
| remap_en | input | 1 | Enables the table search |
| six_way | input | 1 | Six-channel mode; forces the table search |
| fixed_mode | input | 1 | Selects the fixed heterogeneous map |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 4 | Table entry to write |
| tbl_data | input | 6 | Component value to store |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Result taken |
| rsp_id | output | 12 | Logical fabric ID |
| rsp_miss | output | 1 | Search found no match |
| rsp_range_err | output | 1 | Instance number out of range |

## Verification
A corrupted table entry or a wrong priority order shows up as a wrong component field in `rsp_id`. It appears one edge after the affected request is accepted, and never earlier than the first query that reaches that entry. A stuck or wrongly cleared output register shows at once as a lost or duplicated `rsp_valid`, or as data that changes while the output is stalled. A write that leaks into the table while the block is busy is invisible until a later query hits the overwritten entry. For that reason the bench follows each busy-time write with a lookup of the same key.

// File: rtl/stid_pkg.sv
package stid_pkg;
  typedef enum logic [1:0] {
    PATH_PASS   = 2'd0,
    PATH_SEARCH = 2'd1,
    PATH_FIXED  = 2'd2
  } path_e;
endpackage

// File: rtl/stid_remap_table.sv
module stid_remap_table #(
  parameter int COMP_W = 6,
  parameter int DEPTH  = 16,
  localparam int TIDX_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TIDX_W-1:0] widx,
  input  logic [COMP_W-1:0] wdata,
  input  logic [COMP_W-1:0] key,
  output logic [IDX_W-1:0]  idx,
  output logic              found
);
  logic [COMP_W-1:0] entry [DEPTH];
  logic [DEPTH-1:0]  hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         entry[g] <= '0;
      else if (we && widx == TIDX_W'(g))  entry[g] <= wdata;
    end
    assign hit[g] = (entry[g] == key);
  end

  // lowest matching slot wins; DEPTH means no slot matched
  always_comb begin
    idx = IDX_W'(DEPTH);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end

  assign found = |hit;

  // R3
  hit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (entry[idx[TIDX_W-1:0]] == key));
endmodule

// File: rtl/stid_fixed_map.sv
module stid_fixed_map #(
  parameter int ID_W       = 12,
  parameter int NODE_SHIFT = 6,
  parameter int NODE_W     = 6,
  parameter int INST_W     = 6,
  parameter int N_INST     = 32,
  parameter int BANK       = 16,
  parameter int GROUP      = 4
) (
  input  logic [INST_W-1:0] inst,
  input  logic [NODE_W-1:0] node,
  output logic [ID_W-1:0]   id,
  output logic              range_err
);
  // within each bank the group order is reversed; for power-of-two sizes
  // this is an XOR with the group-select bits
  localparam logic [INST_W-1:0] FLIP = INST_W'(BANK - GROUP);

  logic [INST_W-1:0] slot;
  assign slot      = inst ^ FLIP;
  assign range_err = (int'(inst) >= N_INST);
  assign id        = range_err ? '1
                   : (ID_W'(slot) | (ID_W'(node) << NODE_SHIFT));
endmodule

// File: rtl/stid_remapper.sv
module stid_remapper #(
  parameter int ID_W       = 12,
  parameter int COMP_W     = 6,
  parameter int NODE_SHIFT = 6,
  parameter int DEPTH      = 16,
  parameter int INST_W     = 6,
  parameter int N_INST     = 32,
  localparam int NODE_W = ID_W - COMP_W,
  localparam int TIDX_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   phys_id,
  input  logic [INST_W-1:0] inst_id,
  input  logic [NODE_W-1:0] node_id,
  input  logic              remap_en,
  input  logic              six_way,
  input  logic              fixed_mode,
  input  logic              tbl_we,
  input  logic [TIDX_W-1:0] tbl_idx,
  input  logic [COMP_W-1:0] tbl_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic              rsp_miss,
  output logic              rsp_range_err
);
  import stid_pkg::*;

  logic              accept, idle_we, found, fix_err;
  logic [IDX_W-1:0]  idx;
  logic [ID_W-1:0]   node_part, fix_id;
  logic [ID_W-1:0]   nxt_id;
  logic              nxt_miss, nxt_err;
  path_e             path;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign idle_we   = tbl_we && !req_valid && !rsp_valid;

  stid_remap_table #(.COMP_W(COMP_W), .DEPTH(DEPTH)) u_table (
    .clk(clk), .rst_n(rst_n), .we(idle_we), .widx(tbl_idx),
    .wdata(tbl_data), .key(phys_id[COMP_W-1:0]), .idx(idx), .found(found)
  );

  stid_fixed_map #(.ID_W(ID_W), .NODE_SHIFT(NODE_SHIFT), .NODE_W(NODE_W),
                   .INST_W(INST_W), .N_INST(N_INST)) u_fixed (
    .inst(inst_id), .node(node_id), .id(fix_id), .range_err(fix_err)
  );

  assign node_part = {phys_id[ID_W-1:COMP_W], {COMP_W{1'b0}}};

  always_comb begin
    if (fixed_mode)             path = PATH_FIXED;
    else if (remap_en || six_way) path = PATH_SEARCH;
    else                        path = PATH_PASS;
  end

  always_comb begin
    nxt_id   = phys_id;
    nxt_miss = 1'b0;
    nxt_err  = 1'b0;
    case (path)
      PATH_SEARCH: begin
        nxt_id   = node_part | ID_W'(idx);
        nxt_miss = !found;
      end
      PATH_FIXED: begin
        nxt_id  = fix_id;
        nxt_err = fix_err;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_id        <= '0;
      rsp_miss      <= 1'b0;
      rsp_range_err <= 1'b0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_id        <= nxt_id;
      rsp_miss      <= nxt_miss;
      rsp_range_err <= nxt_err;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id)
      && $stable(rsp_miss) && $stable(rsp_range_err)));

  // R7
  range_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_range_err) |-> (rsp_id == '1));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_miss && rsp_range_err));
endmodule

// File: tb/test_stid_remapper.sv
module test_stid_remapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [11:0] phys_id = '0;
  logic [5:0] inst_id = '0, node_id = '0;
  logic remap_en = 1'b0, six_way = 1'b0, fixed_mode = 1'b0;
  logic tbl_we = 1'b0;
  logic [3:0] tbl_idx = '0;
  logic [5:0] tbl_data = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [11:0] rsp_id;
  logic rsp_miss, rsp_range_err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  stid_remapper i_stid_remapper (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .phys_id(phys_id), .inst_id(inst_id), .node_id(node_id),
    .remap_en(remap_en), .six_way(six_way), .fixed_mode(fixed_mode),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
    .rsp_miss(rsp_miss), .rsp_range_err(rsp_range_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [5:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_idx = i; tbl_data = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  // one request with rsp_ready high; checks result at the following negedge
  task automatic query(string req, input logic [2:0] md, input logic [11:0] p,
                       input logic [5:0] ins, input logic [5:0] nd,
                       input logic [11:0] exp_id, input logic exp_miss,
                       input logic exp_err);
    @(negedge clk);
    {fixed_mode, six_way, remap_en} = md;
    phys_id = p; inst_id = ins; node_id = nd; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check(req, {31'd0, rsp_valid}, 32'd1);
    check(req, {20'd0, rsp_id}, {20'd0, exp_id});
    check(req, {30'd0, rsp_miss, rsp_range_err}, {30'd0, exp_miss, exp_err});
  endtask

  task automatic t_reset();
    check("R1", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_pass();
    query("R2", 3'b000, 12'hA53, 6'd0, 6'd0, 12'hA53, 1'b0, 1'b0);
    query("R2", 3'b000, 12'h040, 6'd0, 6'd0, 12'h040, 1'b0, 1'b0);
  endtask

  task automatic t_search();
    for (int i = 0; i < 16; i++) wr(4'(i), 6'(32 + i));
    wr(4'd7, 6'h05);
    wr(4'd11, 6'h05);
    query("R3", 3'b001, 12'hA85, 6'd0, 6'd0, 12'hA87, 1'b0, 1'b0);
    query("R3", 3'b001, 12'h1E3, 6'd0, 6'd0, 12'h1C3, 1'b0, 1'b0);
    query("R4", 3'b001, 12'h040, 6'd0, 6'd0, 12'h050, 1'b1, 1'b0);
    query("R5", 3'b010, 12'hA85, 6'd0, 6'd0, 12'hA87, 1'b0, 1'b0);
  endtask

  task automatic t_fixed();
    query("R6", 3'b101, 12'h000, 6'd0,  6'd3, 12'h0CC, 1'b0, 1'b0);
    query("R6", 3'b100, 12'h000, 6'd5,  6'd0, 12'h009, 1'b0, 1'b0);
    query("R6", 3'b100, 12'h000, 6'd17, 6'd1, 12'h05D, 1'b0, 1'b0);
    query("R6", 3'b111, 12'hA85, 6'd30, 6'd2, 12'h092, 1'b0, 1'b0);
    query("R7", 3'b100, 12'h000, 6'd32, 6'd1, 12'hFFF, 1'b0, 1'b1);
    query("R7", 3'b100, 12'h000, 6'd63, 6'd0, 12'hFFF, 1'b0, 1'b1);
  endtask

  task automatic t_stall();
    logic [11:0] held;
    @(negedge clk);
    rsp_ready = 1'b0; {fixed_mode, six_way, remap_en} = 3'b000;
    phys_id = 12'h3C7; req_valid = 1'b1;
    @(negedge clk);
    check("R8", {31'd0, rsp_valid}, 32'd1);
    held = rsp_id;
    phys_id = 12'h111;
    // write while busy; must be discarded
    tbl_we = 1'b1; tbl_idx = 4'd0; tbl_data = 6'h00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8", {31'd0, req_ready}, 32'd0);
      check("R9", {19'd0, rsp_valid, rsp_id}, {19'd0, 1'b1, held});
    end
    tbl_we = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9", {20'd0, rsp_id}, 32'h111);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8", {31'd0, rsp_valid}, 32'd0);
    query("R10", 3'b001, 12'h040, 6'd0, 6'd0, 12'h050, 1'b1, 1'b0);
    wr(4'd2, 6'h00);
    query("R10", 3'b001, 12'h040, 6'd0, 6'd0, 12'h042, 1'b0, 1'b0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_search();
    t_fixed();
    t_stall();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule